// File: doc/BRIEF.md
# Four-Rail Power-Up Sequencer

This block brings up four regulator rails one after another. A start request picks one of six fixed rail orderings. For each rail in that ordering, the block counts out a per-rail lead-in delay and then raises the rail's enable. It then counts a per-rail ramp delay, and only after that does it look at the rail's power-good input. Once every rail has passed its check, the block moves into a monitoring state and raises an all-good status.

A rail that is not good at the end of its ramp causes a global shutdown: every enable drops, a fault flag rises, and the index of the failing rail is held. The same happens when a rail loses power-good during monitoring, in which case the lowest failing index is recorded. The block stays halted until a rising edge on the restart input. That edge runs the sequence again from the first rail of the ordering captured at start. Power-down ordering is not part of this block.

Top module: `rail_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start request is sampled, all enables, the fault flag and the all-good status are low.
- R2: The order code is captured when start is accepted. Codes 0 to 5 give these rail orders: 0 = 0,1,2,3; 1 = 3,2,1,0; 2 = 1,0,3,2; 3 = 2,3,0,1; 4 = 0,2,1,3; 5 = 3,1,2,0. Codes 6 and 7 behave as code 0.
- R3: Rail r's enable rises gap_dly[r]+1 clock cycles after the cycle in which the sequencer moves to rail r. That cycle is the start or restart acceptance for the first rail, and the previous rail's passing check for every later rail. Rail r's delay sits in bits [16r+15:16r] of gap_dly.
- R4: Rail r's power-good is sampled exactly ramp_dly[r]+1 cycles after its enable rises (the same field layout as gap_dly). A low power-good before that cycle has no effect.
- R5: A rail that fails its check clears all enables on the next cycle, raises fault, and sets fault_rail to that rail's index. While the block is faulted, power-good changes have no effect.
- R6: After the last rail in the order passes, all_good is high and all four enables are high.
- R7: While all_good is high, any low power-good bit causes the R5 shutdown, and fault_rail reports the lowest index among the low bits.
- R8: Fault is held until restart rises. A restart that stays high causes only one new sequence. The new sequence uses the captured order and clears fault_rail to 0.
- R9: Start is ignored unless the block is idle, and restart is ignored unless the block is faulted.
- R10: At most one enable rises in any cycle, and an enable only falls on a shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin sequencing (level, accepted only when idle) |
| restart | input | 1 | Restart switch; its rising edge clears a fault |
| order_sel | input | 3 | Rail-order code |
| gap_dly | input | 4*DLY_W | Per-rail delay before enable, rail r in field r |
| ramp_dly | input | 4*DLY_W | Per-rail ramp delay before the power-good check |
| pgood | input | 4 | Per-rail power-good |
| rail_en | output | 4 | Regulator enables |
| fault | output | 1 | Sequencer halted by a failed rail |
| fault_rail | output | 2 | Index of the failing rail |
| all_good | output | 1 | All rails up and being monitored |

## Verification
Several properties are checked on every cycle: the enables are empty while faulted, at most one enable rises per cycle, all_good implies every enable, a power-good loss under all_good leads to fault, and a fault persists until a restart edge. The bench's scenarios are what show the actual rail orders for every code, the exact delay counts, and the lowest-index choice of fault_rail. They also show that a held restart gives only one new sequence and that stray start and restart pulses have no effect. A behavioural reference model is compared with every output on every cycle.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  localparam int RAILS  = 4;
  localparam int IDX_W  = 2;
  localparam int MODES  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_RAMP,
    ST_MON,
    ST_HALT
  } seq_state_t;

  // Fold unused codes onto the default ordering.
  function automatic logic [2:0] norm_mode(input logic [2:0] code);
    return (int'(code) >= MODES) ? 3'd0 : code;
  endfunction

  // Rail visited at a given step; each word packs step s in bits [2s+1:2s].
  function automatic logic [IDX_W-1:0] step_rail(input logic [2:0] mode,
                                                 input logic [IDX_W-1:0] step);
    logic [2*RAILS-1:0] word;
    case (norm_mode(mode))
      3'd1:    word = 8'h1B;
      3'd2:    word = 8'hB1;
      3'd3:    word = 8'h4E;
      3'd4:    word = 8'hD8;
      3'd5:    word = 8'h27;
      default: word = 8'hE4;
    endcase
    return word[int'(step)*2 +: 2];
  endfunction

  // Lowest-index rail whose power-good is low.
  function automatic logic [IDX_W-1:0] first_low(input logic [RAILS-1:0] pg);
    if (!pg[0])      return 2'd0;
    else if (!pg[1]) return 2'd1;
    else if (!pg[2]) return 2'd2;
    else             return 2'd3;
  endfunction

endpackage

// File: rtl/rail_seq_order.sv
module rail_seq_order
  import rail_seq_pkg::*;
(
  input  logic [2:0]       mode,
  input  logic [IDX_W-1:0] step,
  output logic [IDX_W-1:0] rail
);
  assign rail = step_rail(mode, step);
endmodule

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/rail_seq_edge.sv
module rail_seq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/rail_seq.sv
module rail_seq
  import rail_seq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   restart,
  input  logic [2:0]             order_sel,
  input  logic [RAILS*DLY_W-1:0] gap_dly,
  input  logic [RAILS*DLY_W-1:0] ramp_dly,
  input  logic [RAILS-1:0]       pgood,
  output logic [RAILS-1:0]       rail_en,
  output logic                   fault,
  output logic [IDX_W-1:0]       fault_rail,
  output logic                   all_good
);

  localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(RAILS - 1);

  seq_state_t       state;
  logic [2:0]       mode_q;
  logic [IDX_W-1:0] step;

  // Named events, also watched by the checker.
  logic             restart_rise;
  logic             tmr_zero;
  logic             go_start, go_restart, gap_done, ramp_done;
  logic             check_ok, check_bad, mon_loss;
  logic [2:0]       first_mode;
  logic [IDX_W-1:0] first_rail, cur_rail, nxt_rail;
  logic             tmr_load;
  logic [DLY_W-1:0] tmr_val;

  rail_seq_edge u_rst_edge (
    .clk(clk), .rst_n(rst_n), .din(restart), .rise(restart_rise)
  );

  assign first_mode = (state == ST_IDLE) ? norm_mode(order_sel) : mode_q;

  rail_seq_order u_ord_first (.mode(first_mode), .step('0),        .rail(first_rail));
  rail_seq_order u_ord_cur   (.mode(mode_q),     .step(step),        .rail(cur_rail));
  rail_seq_order u_ord_nxt   (.mode(mode_q),     .step(step + 1'b1), .rail(nxt_rail));

  assign go_start   = (state == ST_IDLE) && start;
  assign go_restart = (state == ST_HALT) && restart_rise;
  assign gap_done   = (state == ST_GAP)  && tmr_zero;
  assign ramp_done  = (state == ST_RAMP) && tmr_zero;
  assign check_ok   = ramp_done &&  pgood[cur_rail];
  assign check_bad  = ramp_done && !pgood[cur_rail];
  assign mon_loss   = (state == ST_MON) && (pgood != {RAILS{1'b1}});

  always_comb begin
    tmr_load = 1'b1;
    if (go_start || go_restart)
      tmr_val = gap_dly[int'(first_rail)*DLY_W +: DLY_W];
    else if (gap_done)
      tmr_val = ramp_dly[int'(cur_rail)*DLY_W +: DLY_W];
    else if (check_ok && step != LAST_STEP)
      tmr_val = gap_dly[int'(nxt_rail)*DLY_W +: DLY_W];
    else begin
      tmr_load = 1'b0;
      tmr_val  = '0;
    end
  end

  rail_seq_timer #(.W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_q     <= 3'd0;
      step       <= '0;
      rail_en    <= '0;
      fault_rail <= '0;
    end else begin
      if (go_start || go_restart) begin
        mode_q     <= first_mode;
        step       <= '0;
        fault_rail <= '0;
        state      <= ST_GAP;
      end else if (gap_done) begin
        rail_en[cur_rail] <= 1'b1;
        state             <= ST_RAMP;
      end else if (check_ok) begin
        if (step == LAST_STEP) begin
          state <= ST_MON;
        end else begin
          step  <= step + 1'b1;
          state <= ST_GAP;
        end
      end else if (check_bad) begin
        rail_en    <= '0;
        fault_rail <= cur_rail;
        state      <= ST_HALT;
      end else if (mon_loss) begin
        rail_en    <= '0;
        fault_rail <= first_low(pgood);
        state      <= ST_HALT;
      end
    end
  end

  assign fault    = (state == ST_HALT);
  assign all_good = (state == ST_MON);

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       restart_rise,
  input logic [3:0] pgood,
  input logic [3:0] rail_en,
  input logic       fault,
  input logic       all_good
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (rail_en == 4'h0 && !fault && !all_good));

  // R5
  halt_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (rail_en == 4'h0));

  // R10
  one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rail_en & ~$past(rail_en)) <= 1);

  // R10
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en != 4'h0 && !fault) |=> (fault || ((rail_en & $past(rail_en)) == $past(rail_en))));

  // R6
  good_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_good |-> (rail_en == 4'hF && !fault));

  // R7
  mon_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_good && pgood != 4'hF) |=> fault);

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !restart_rise) |=> fault);

  // R8
  halt_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && restart_rise) |=> !fault);

endmodule

bind rail_seq rail_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .restart_rise(restart_rise), .pgood(pgood),
  .rail_en(rail_en), .fault(fault), .all_good(all_good)
);

// File: tb/rail_seq_tb.sv
module rail_seq_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          restart = 1'b0;
  logic [2:0]    order_sel = 3'd0;
  logic [4*DW-1:0] gap_dly, ramp_dly;
  logic [3:0]    pgood = 4'hF;
  logic [3:0]    rail_en;
  logic          fault;
  logic [1:0]    fault_rail;
  logic          all_good;

  rail_seq #(.DLY_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .restart(restart),
    .order_sel(order_sel), .gap_dly(gap_dly), .ramp_dly(ramp_dly),
    .pgood(pgood), .rail_en(rail_en), .fault(fault),
    .fault_rail(fault_rail), .all_good(all_good)
  );

  always #5 clk = ~clk;

  int    checks = 0, errors = 0, cyc = 0;
  string req = "R1";
  bit    follow = 1'b0;
  int    gaps[4], ramps[4];
  int    ord[8][4];
  int    seen[$];
  logic [3:0] prev_en = 4'h0;

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  // Reference model: phases 0 idle, 1 gap, 2 ramp, 3 monitor, 4 halted.
  int   m_ph = 0, m_step = 0, m_cnt = 0, m_mode = 0, m_fr = 0;
  bit [3:0] m_en = 0;
  bit   m_rprev = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_step = 0; m_cnt = 0; m_mode = 0; m_fr = 0; m_en = 0; m_rprev = 0;
    end else begin
      automatic bit rise = restart && !m_rprev;
      automatic int r = ord[m_mode][m_step];
      m_rprev = restart;
      case (m_ph)
        0: if (start) begin
             m_mode = order_sel; m_step = 0; m_fr = 0;
             m_cnt = gaps[ord[m_mode][0]]; m_ph = 1;
           end
        1: if (m_cnt == 0) begin m_en[r] = 1; m_cnt = ramps[r]; m_ph = 2; end
           else m_cnt--;
        2: if (m_cnt == 0) begin
             if (pgood[r]) begin
               if (m_step == 3) m_ph = 3;
               else begin m_step++; m_cnt = gaps[ord[m_mode][m_step]]; m_ph = 1; end
             end else begin m_en = 0; m_fr = r; m_ph = 4; end
           end else m_cnt--;
        3: if (pgood != 4'hF) begin
             m_en = 0; m_ph = 4;
             for (int i = 3; i >= 0; i--) if (!pgood[i]) m_fr = i;
           end
        default: if (rise) begin
             m_step = 0; m_fr = 0; m_cnt = gaps[ord[m_mode][0]]; m_ph = 1;
           end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rail_en == m_en, req, "rail_en", rail_en, m_en);
      chk(fault == (m_ph == 4), req, "fault", fault, m_ph == 4);
      chk(all_good == (m_ph == 3), req, "all_good", all_good, m_ph == 3);
      chk(fault_rail == 2'(m_fr), req, "fault_rail", fault_rail, m_fr);
    end
    for (int i = 0; i < 4; i++) if (rail_en[i] && !prev_en[i]) seen.push_back(i);
    prev_en = rail_en;
    if (follow) pgood = rail_en;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    seen.delete();
    @(negedge clk);
  endtask

  task automatic pulse_start(input int mode, output int t);
    order_sel = 3'(mode);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = cyc;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 400 && !(all_good || fault); k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, t2;
    ord[0] = '{0,1,2,3}; ord[1] = '{3,2,1,0}; ord[2] = '{1,0,3,2};
    ord[3] = '{2,3,0,1}; ord[4] = '{0,2,1,3}; ord[5] = '{3,1,2,0};
    ord[6] = ord[0];     ord[7] = ord[0];
    for (int r = 0; r < 4; r++) begin
      gaps[r] = r + 1; ramps[r] = 2 * r + 1;
      gap_dly[r*DW +: DW]  = DW'(gaps[r]);
      ramp_dly[r*DW +: DW] = DW'(ramps[r]);
    end

    // R1: reset state and idle without start; R9: restart while idle.
    req = "R1";
    repeat (2) @(negedge clk);
    chk(rail_en == 0 && !fault && !all_good, "R1", "reset outputs", rail_en, 0);
    do_reset();
    restart = 1'b1; @(negedge clk); restart = 1'b0;
    repeat (6) @(negedge clk);
    chk(rail_en == 0 && !fault && !all_good, "R9", "idle after restart pulse", rail_en, 0);

    // R3/R4/R5: exact delays with power-good stuck low.
    req = "R4";
    pgood = 4'h0;
    pulse_start(0, t0);
    for (int k = 0; k < 50 && !rail_en[0]; k++) @(negedge clk);
    t1 = cyc;
    chk(t1 - t0 == gaps[0] + 1, "R3", "cycles to first enable", t1 - t0, gaps[0] + 1);
    for (int k = 0; k < 50 && !fault; k++) @(negedge clk);
    t2 = cyc;
    chk(t2 - t1 == ramps[0] + 1, "R4", "cycles enable to check", t2 - t1, ramps[0] + 1);
    chk(fault_rail == 0, "R5", "fault_rail", fault_rail, 0);
    chk(rail_en == 0, "R5", "enables after fail", rail_en, 0);

    // R2/R6/R10 for every code; power-good only follows enables (R4 gating).
    for (int m = 0; m < 8; m++) begin
      req = "R2";
      do_reset();
      pgood = 4'h0; follow = 1'b1;
      pulse_start(m, t0);
      if (m == 2) begin
        // R9: stray start and restart while running.
        repeat (4) @(negedge clk);
        start = 1'b1; restart = 1'b1; @(negedge clk);
        start = 1'b0; restart = 1'b0;
      end
      wait_done();
      chk(all_good && !fault, "R6", "all_good after sequence", all_good, 1);
      chk(rail_en == 4'hF, "R10", "all enables held", rail_en, 15);
      chk(seen.size() == 4, "R2", "enable count", seen.size(), 4);
      for (int i = 0; i < 4 && i < seen.size(); i++)
        chk(seen[i] == ord[m][i], "R2", $sformatf("mode %0d step %0d rail", m, i),
            seen[i], ord[m][i]);
      follow = 1'b0;
    end

    // R5: order 3,2,1,0 with rail 2 failing its check.
    req = "R5";
    do_reset();
    pgood = 4'b1011;
    pulse_start(1, t0);
    wait_done();
    chk(fault && fault_rail == 2, "R5", "failing rail", fault_rail, 2);
    chk(rail_en == 0, "R5", "enables dark", rail_en, 0);
    pgood = 4'hF;
    repeat (5) @(negedge clk);
    chk(fault && rail_en == 0, "R5", "pgood ignored while halted", rail_en, 0);

    // R8: held restart gives exactly one new sequence.
    req = "R8";
    restart = 1'b1;
    @(negedge clk);
    wait_done();
    chk(all_good, "R8", "restart sequence completes", all_good, 1);
    pgood = 4'b1101;
    @(negedge clk);
    @(negedge clk);
    chk(fault && fault_rail == 1, "R7", "monitor loss rail", fault_rail, 1);
    pgood = 4'hF;
    repeat (20) @(negedge clk);
    chk(fault && rail_en == 0, "R8", "held restart no retrigger", fault, 1);
    restart = 1'b0; @(negedge clk);
    restart = 1'b1; @(negedge clk); restart = 1'b0;
    chk(!fault && fault_rail == 0, "R8", "fault cleared by edge", fault, 0);
    wait_done();
    chk(all_good && seen[seen.size()-1] == 0, "R8", "order kept on restart",
        seen[seen.size()-1], 0);

    // R7: two rails lost at once; lowest index reported.
    req = "R7";
    pgood = 4'b0101;
    @(negedge clk); @(negedge clk);
    chk(fault && fault_rail == 1, "R7", "lowest low rail", fault_rail, 1);
    chk(rail_en == 0, "R7", "shutdown", rail_en, 0);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule